// File: doc/BRIEF.md
# Address-triggered sector erase sequencer

This block stands between a byte-write request port and the controller of a nonvolatile memory split into two equal sectors. The sector of a byte is picked by the most significant bit of its address. Each sector has one trigger address, set by a parameter. By default the lower sector's trigger is address zero and the upper sector's trigger is half the memory size, which is the first byte of the upper sector.

A write whose address equals the trigger of its own sector becomes a two-step sequence. The block first commands an erase of that whole sector and waits for the memory to report completion. It then commands a program of the requested byte at that same address and waits again. Any other write becomes a single program command.

From the cycle after a request is accepted until the final completion, the block holds a busy flag that can be polled. While busy it refuses new requests.

Top module: `sector_erase_seq`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, and `erase_cmd` and `prog_cmd` are both 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. If its address is not a trigger, `prog_cmd` goes high for exactly one cycle, in the cycle after acceptance, and `erase_cmd` stays 0 for the whole transaction. In that cycle `prog_addr` and `prog_data` carry the request's address and data. `erase_cmd` and `prog_cmd` are never high together.
- R3: An accepted write to the lower sector's trigger (default 0x000 with the default 9-bit address) raises `erase_cmd` for exactly one cycle, in the cycle after acceptance, with `erase_sector` = 0.
- R4: An accepted write to the upper sector's trigger (default 0x100) raises `erase_cmd` with `erase_sector` = 1. `erase_sector` always equals the MSB of the held address. An address in the upper sector other than its trigger, such as 0x101, is a plain write.
- R5: In a triggered sequence, the cycle after `mem_done` is seen following the erase command is the program command cycle. In that cycle `prog_addr` and `prog_data` equal the original request's address and data.
- R6: `busy` is 1 from the cycle after acceptance until the cycle after `mem_done` is seen during the program step, and `req_ready` is the inverse of `busy`. A request presented while busy, including one presented in the cycle of the final `mem_done`, is not accepted and leaves the held address and data unchanged.
- R7: A `mem_done` that arrives in a command cycle itself completes that step. The next command follows in the next cycle, or the block goes idle in the next cycle.
- R8: `mem_done` while idle with no request has no effect: `busy` stays 0 and no command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | DATA_W | Byte to write |
| req_ready | output | 1 | Block can accept a request |
| busy | output | 1 | Sequence in progress, for polling |
| erase_cmd | output | 1 | One-cycle sector erase command |
| erase_sector | output | 1 | Sector to erase |
| prog_cmd | output | 1 | One-cycle byte program command |
| prog_addr | output | ADDR_W | Address to program |
| prog_data | output | DATA_W | Byte to program |
| mem_done | input | 1 | Completion pulse from the memory controller |

## Verification
Two pairs of events can land in the same cycle. The first pair is a completion pulse and the command it answers: the bench raises `mem_done` inside the erase command cycle and inside the program command cycle. It judges that the next step, or idle, follows one cycle later. The second pair is the final completion and a new request: the bench holds `req_valid` with another address across the last `mem_done`. It checks that the program address did not change and that busy falls with no command, so acceptance comes only once the block reports ready.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_EWAIT = 3'd2,
    ST_PROG  = 3'd3,
    ST_PWAIT = 3'd4
  } seq_state_t;

endpackage

// File: rtl/ses_rst_sync.sv
module ses_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ses_trigger_match.sv
module ses_trigger_match #(
  parameter int ADDR_W   = 9,
  parameter int NUM_SECT = 2,
  parameter logic [NUM_SECT*ADDR_W-1:0] TRIG_FLAT = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int SECT_W = $clog2(NUM_SECT);

  logic [NUM_SECT-1:0] hit_vec;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    // a trigger only counts inside the sector it erases
    assign hit_vec[s] = (addr[ADDR_W-1 -: SECT_W] == SECT_W'(s)) &&
                        (addr == TRIG_FLAT[s*ADDR_W +: ADDR_W]);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/ses_req_latch.sv
module ses_req_latch #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (load) begin
      addr_d = addr_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/ses_ctrl_fsm.sv
module ses_ctrl_fsm
  import sector_erase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic trig_hit,
  input  logic mem_done,
  output logic accept,
  output logic busy,
  output logic erase_cmd,
  output logic prog_cmd
);

  seq_state_t state_q, state_d;

  assign busy   = (state_q != ST_IDLE);
  assign accept = req_valid && !busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)   state_d = trig_hit ? ST_ERASE : ST_PROG;
      ST_ERASE: state_d = mem_done ? ST_PROG : ST_EWAIT;
      ST_EWAIT: if (mem_done) state_d = ST_PROG;
      ST_PROG:  state_d = mem_done ? ST_IDLE : ST_PWAIT;
      ST_PWAIT: if (mem_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign erase_cmd = (state_q == ST_ERASE);
  assign prog_cmd  = (state_q == ST_PROG);

  assert_erase_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_cmd |=> !erase_cmd);

  assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_cmd |=> !prog_cmd);

  assert_done_in_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cmd && mem_done) |=> prog_cmd);

  assert_erase_then_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_cmd && !prog_cmd && mem_done && $past(erase_cmd || state_q == ST_EWAIT))
      |=> (prog_cmd || !busy));

  assert_accept_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_done && !req_valid) |=> !busy);

endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_SECT0 = '0,
  parameter logic [ADDR_W-1:0] TRIG_SECT1 = {1'b1, {(ADDR_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              erase_cmd,
  output logic              erase_sector,
  output logic              prog_cmd,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  input  logic              mem_done
);

  localparam int NUM_SECT = 2;
  localparam logic [NUM_SECT*ADDR_W-1:0] TRIG_FLAT = {TRIG_SECT1, TRIG_SECT0};

  logic rst_n_s;
  logic trig_hit;
  logic accept;

  ses_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ses_trigger_match #(
    .ADDR_W   (ADDR_W),
    .NUM_SECT (NUM_SECT),
    .TRIG_FLAT(TRIG_FLAT)
  ) u_match (
    .addr (req_addr),
    .hit  (trig_hit)
  );

  ses_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (accept),
    .addr_in (req_addr),
    .data_in (req_data),
    .addr_q  (prog_addr),
    .data_q  (prog_data)
  );

  ses_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .trig_hit  (trig_hit),
    .mem_done  (mem_done),
    .accept    (accept),
    .busy      (busy),
    .erase_cmd (erase_cmd),
    .prog_cmd  (prog_cmd)
  );

  assign req_ready    = !busy;
  assign erase_sector = prog_addr[ADDR_W-1];

  assert_cmd_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(erase_cmd && prog_cmd));

  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(busy) && busy) |-> $stable(prog_addr) && $stable(prog_data));

  assert_ready_rises_idle_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(req_ready) |-> !erase_cmd && !prog_cmd);

endmodule

// File: tb/sector_erase_seq_tb_top.sv
module sector_erase_seq_tb_top;

  localparam int AW = 9;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_ready;
  logic          busy;
  logic          erase_cmd;
  logic          erase_sector;
  logic          prog_cmd;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          mem_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  sector_erase_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_ready    (req_ready),
    .busy         (busy),
    .erase_cmd    (erase_cmd),
    .erase_sector (erase_sector),
    .prog_cmd     (prog_cmd),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .mem_done     (mem_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_cmds(input string tag);
    chk({tag, " erase_cmd"}, int'(erase_cmd), 0);
    chk({tag, " prog_cmd"},  int'(prog_cmd),  0);
  endtask

  task automatic t_reset();
    chk("R1 busy",  int'(busy), 0);
    chk("R1 ready", int'(req_ready), 1);
    idle_cmds("R1");
  endtask

  task automatic t_plain(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 prog_cmd", int'(prog_cmd), 1);
    chk("R2 erase_cmd", int'(erase_cmd), 0);
    chk("R2 prog_addr", int'(prog_addr), int'(a));
    chk("R2 prog_data", int'(prog_data), int'(d));
    chk("R6 busy after accept", int'(busy), 1);
    chk("R6 ready low", int'(req_ready), 0);
    @(negedge clk);
    idle_cmds("R2 wait");
    chk("R6 busy in wait", int'(busy), 1);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    chk("R6 busy cleared", int'(busy), 0);
    idle_cmds("R2 end");
  endtask

  task automatic t_trig(input logic [AW-1:0] a, input logic [DW-1:0] d, input int sect);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    chk(sect == 0 ? "R3 erase_cmd" : "R4 erase_cmd", int'(erase_cmd), 1);
    chk(sect == 0 ? "R3 sector" : "R4 sector", int'(erase_sector), sect);
    chk("R2 no prog with erase", int'(prog_cmd), 0);
    // another request held while busy must be refused
    req_addr = a ^ 9'h055; req_data = ~d;
    @(negedge clk);
    chk("R3 erase one cycle", int'(erase_cmd), 0);
    chk("R5 no prog before done", int'(prog_cmd), 0);
    chk("R6 busy during erase", int'(busy), 1);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    chk("R5 prog after erase", int'(prog_cmd), 1);
    chk("R5 prog_addr", int'(prog_addr), int'(a));
    chk("R5 prog_data", int'(prog_data), int'(d));
    // final done coincides with a still-held request
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    req_valid = 1'b0;
    chk("R6 busy clears with req held", int'(busy), 0);
    chk("R6 held addr unchanged", int'(prog_addr), int'(a));
    idle_cmds("R6 final");
    @(negedge clk);
    chk("R6 refused req not started", int'(busy), 0);
  endtask

  task automatic t_fast_done();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 9'h100; req_data = 8'h3c;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 erase_cmd", int'(erase_cmd), 1);
    mem_done = 1'b1;
    @(negedge clk);
    chk("R7 prog next cycle", int'(prog_cmd), 1);
    chk("R7 prog_data", int'(prog_data), 8'h3c);
    @(negedge clk);
    mem_done = 1'b0;
    chk("R7 idle after done in prog cycle", int'(busy), 0);
    idle_cmds("R7 end");
  endtask

  task automatic t_idle_done();
    @(negedge clk);
    mem_done = 1'b1;
    @(negedge clk);
    chk("R8 busy", int'(busy), 0);
    idle_cmds("R8");
    @(negedge clk);
    mem_done = 1'b0;
    chk("R8 still idle", int'(busy), 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; mem_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain(9'h055, 8'ha5);
    t_plain(9'h1ff, 8'h01);
    t_plain(9'h101, 8'h7e);
    t_plain(9'h080, 8'hc3);
    t_trig(9'h000, 8'h5a, 0);
    t_trig(9'h100, 8'h96, 1);
    t_fast_done();
    t_idle_done();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_run();
  end

endmodule